// File: doc/BRIEF.md
# Interrupt-Routing GPIO Port

This block is a general purpose I/O port of 1 to 32 lines with a 32-bit register bus in the style of APB. Every line has an output value, a direction bit and a synchronized input sample. Each line can also raise an interrupt. Two configuration bits per line choose level or edge sensitivity and the active sense. An enable bit per line gates that line's interrupt.

A byte-wide map entry per line steers the line's interrupt onto one of `N_IRQ` shared interrupt wires, or onto none of them. Each wire is the OR of the lines routed to it. A level condition holds the wire high for as long as the condition is true. An edge gives a pulse of one clock.

Software reaches the registers with whole-word accesses, so the byte order of the bus has no effect on the layout. A spare read/write scratch word is provided. The pads, the bus bridge and the interrupt controller live outside the block.

Top module: `gpio_irq_router`

## Requirements
- R1: The parameter `N_LINES` sets the line count when it is between 1 and 32. Any other value makes the block build 32 lines.
- R2: After reset the following hold:
  - the direction register reads 0 and `pin_oe` is 0;
  - the enable register reads 0 and `irq_out` is 0;
  - every implemented map byte reads 0xFF.
- R3: A write to the output word (offset 0x04) appears on `pin_out` in the next cycle. A write to the direction word (offset 0x08) appears on `pin_oe` in the next cycle. A direction bit of 1 means the line drives its output value.
- R4: A read of offset 0x00 returns the pin levels after a two-flop synchronizer, so the value sampled two clocks earlier. Writes to offset 0x00 have no effect.
- R5: Bit n of a per-line register belongs to line n, and bits at or above the line count read 0. The following read 0, and writes to them are ignored:
  - misaligned addresses;
  - offset 0x1C;
  - map words past the last implemented line.
- R6: With edge bit (offset 0x14) 0, the line is level sensitive. Polarity bit (offset 0x10) 1 means active high, and 0 means active low. The routed wire stays high while the synchronized level matches.
- R7: With edge bit 1, polarity 1 selects rising edges and polarity 0 selects falling edges. Each edge gives exactly one cycle of `irq_out`. The opposite edge gives nothing.
- R8: A line raises nothing while its enable bit (offset 0x0C) is 0. Clearing the enable bit leaves the polarity, edge and map settings unchanged. Setting it again restores the interrupt.
- R9: The map starts at offset 0x20. It holds one signed byte per line, four lines per word, and line 4k sits in bits 31:24 of word k. A value v with 0 <= v < N_IRQ routes the line to `irq_out[v]`. A negative value or a value >= N_IRQ leaves the line unrouted.
- R10: Several lines may share one wire, and the wire is the OR of them. Lines on different wires act independently.
- R11: Offset 0x18 is a read/write scratch word, one bit per line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| psel | input | 1 | bus select |
| penable | input | 1 | bus access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | ADDR_W | byte address |
| pwdata | input | 32 | write data |
| prdata | output | 32 | read data, zero when not selected |
| pin_in | input | NL | pad input levels |
| pin_out | output | NL | output register value |
| pin_oe | output | NL | drive enable per line |
| irq_out | output | N_IRQ | routed interrupt wires |

## Verification
The hardest condition to reach from the ports is an edge pulse whose timing and wire can be told apart from a level. The stimulus first parks the pin at the idle level of the chosen mode while the line is still disabled. It then configures the line and moves the pin once. It samples the wire exactly two cycles later and again one cycle after that. This is done for every line, every trigger mode and a rotating target wire, so a swapped polarity, a stuck pulse or a wrong byte lane each shows up.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int MAX_LINES = 32;
    localparam int WORD_W    = 32;
    localparam int MAP_BYTE  = 8;

    // word indices (byte offset / 4)
    localparam int W_DATA = 0;
    localparam int W_OUT  = 1;
    localparam int W_DIR  = 2;
    localparam int W_EN   = 3;
    localparam int W_POL  = 4;
    localparam int W_EDGE = 5;
    localparam int W_SCR  = 6;
    localparam int W_MAP  = 8;

    // encoding is {edge, polarity}
    typedef enum logic [1:0] {
        TRIG_LOW_LVL  = 2'b00,
        TRIG_HIGH_LVL = 2'b01,
        TRIG_FALL     = 2'b10,
        TRIG_RISE     = 2'b11
    } trig_e;

    typedef struct packed {
        logic en;
        logic pol;
        logic edg;
    } line_cfg_t;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_OUT, SEL_DIR, SEL_EN,
        SEL_POL, SEL_EDGE, SEL_SCR, SEL_MAP
    } reg_sel_e;

    typedef struct packed {
        logic               wr_en;
        reg_sel_e           sel;
        logic [2:0]         map_word;
        logic [WORD_W-1:0]  wdata;
    } bus_op_t;

    function automatic int clamp_lines(int n);
        return (n < 1 || n > MAX_LINES) ? MAX_LINES : n;
    endfunction

    function automatic logic line_hit(trig_e mode, logic cur, logic prv);
        case (mode)
            TRIG_LOW_LVL:  return ~cur;
            TRIG_HIGH_LVL: return cur;
            TRIG_FALL:     return prv & ~cur;
            default:       return cur & ~prv;
        endcase
    endfunction

    function automatic logic routes_to(logic [MAP_BYTE-1:0] m, int n_out, int target);
        return (m[MAP_BYTE-1] == 1'b0) && (target < n_out) &&
               (int'(m[MAP_BYTE-2:0]) == target);
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NL     = 32,
    parameter int ADDR_W = 8,
    localparam int MAP_WORDS = (NL + 3) / 4,
    localparam int WIDX_W    = ADDR_W - 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     psel,
    input  logic                     penable,
    input  logic                     pwrite,
    input  logic [ADDR_W-1:0]        paddr,
    input  logic [WORD_W-1:0]        pwdata,
    output logic [WORD_W-1:0]        prdata,
    input  logic [NL-1:0]            pin_sync,
    output logic [NL-1:0]            out_q,
    output logic [NL-1:0]            dir_q,
    output line_cfg_t [NL-1:0]       cfg_q,
    output logic [NL-1:0][MAP_BYTE-1:0] map_q
);

    logic [NL-1:0]     en_q, pol_q, edg_q, scr_q;
    logic [WIDX_W-1:0] widx;
    bus_op_t           op;
    logic [WORD_W-1:0] rd;

    assign widx = paddr[ADDR_W-1:2];

    always_comb begin
        op.wr_en    = psel & penable & pwrite;
        op.wdata    = pwdata;
        op.sel      = SEL_NONE;
        op.map_word = '0;
        if (paddr[1:0] == 2'b00) begin
            case (int'(widx))
                W_DATA: op.sel = SEL_DATA;
                W_OUT:  op.sel = SEL_OUT;
                W_DIR:  op.sel = SEL_DIR;
                W_EN:   op.sel = SEL_EN;
                W_POL:  op.sel = SEL_POL;
                W_EDGE: op.sel = SEL_EDGE;
                W_SCR:  op.sel = SEL_SCR;
                default: begin
                    if (int'(widx) >= W_MAP && int'(widx) < W_MAP + MAP_WORDS) begin
                        op.sel      = SEL_MAP;
                        op.map_word = 3'(int'(widx) - W_MAP);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
            en_q  <= '0;
            pol_q <= '0;
            edg_q <= '0;
            scr_q <= '0;
            for (int i = 0; i < NL; i++) map_q[i] <= '1;
        end else if (op.wr_en) begin
            case (op.sel)
                SEL_OUT:  out_q <= op.wdata[NL-1:0];
                SEL_DIR:  dir_q <= op.wdata[NL-1:0];
                SEL_EN:   en_q  <= op.wdata[NL-1:0];
                SEL_POL:  pol_q <= op.wdata[NL-1:0];
                SEL_EDGE: edg_q <= op.wdata[NL-1:0];
                SEL_SCR:  scr_q <= op.wdata[NL-1:0];
                SEL_MAP: begin
                    for (int i = 0; i < NL; i++)
                        if (i / 4 == int'(op.map_word))
                            map_q[i] <= op.wdata[WORD_W-1-MAP_BYTE*(i%4) -: MAP_BYTE];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd = '0;
        case (op.sel)
            SEL_DATA: rd[NL-1:0] = pin_sync;
            SEL_OUT:  rd[NL-1:0] = out_q;
            SEL_DIR:  rd[NL-1:0] = dir_q;
            SEL_EN:   rd[NL-1:0] = en_q;
            SEL_POL:  rd[NL-1:0] = pol_q;
            SEL_EDGE: rd[NL-1:0] = edg_q;
            SEL_SCR:  rd[NL-1:0] = scr_q;
            SEL_MAP: begin
                for (int i = 0; i < NL; i++)
                    if (i / 4 == int'(op.map_word))
                        rd[WORD_W-1-MAP_BYTE*(i%4) -: MAP_BYTE] = map_q[i];
            end
            default: ;
        endcase
        prdata = psel ? rd : '0;
    end

    for (genvar g = 0; g < NL; g++) begin : g_cfg
        assign cfg_q[g] = '{en: en_q[g], pol: pol_q[g], edg: edg_q[g]};
    end

endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
    import gpio_pkg::*;
#(
    parameter int NL = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NL-1:0]      pin_in,
    input  line_cfg_t [NL-1:0] cfg,
    output logic [NL-1:0]      pin_sync,
    output logic [NL-1:0]      line_irq
);

    logic [NL-1:0] s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= pin_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign pin_sync = s2_q;

    for (genvar g = 0; g < NL; g++) begin : g_line
        trig_e mode;
        assign mode        = trig_e'({cfg[g].edg, cfg[g].pol});
        assign line_irq[g] = cfg[g].en & line_hit(mode, s2_q[g], prev_q[g]);
    end

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
    import gpio_pkg::*;
#(
    parameter int NL    = 32,
    parameter int N_IRQ = 4
) (
    input  logic [NL-1:0]               line_irq,
    input  logic [NL-1:0][MAP_BYTE-1:0] map,
    output logic [N_IRQ-1:0]            irq_out
);

    logic [N_IRQ-1:0][NL-1:0] sel_m;

    for (genvar o = 0; o < N_IRQ; o++) begin : g_out
        for (genvar i = 0; i < NL; i++) begin : g_src
            assign sel_m[o][i] = routes_to(map[i], N_IRQ, o);
        end
        assign irq_out[o] = |(line_irq & sel_m[o]);
    end

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int N_IRQ   = 4,
    parameter int ADDR_W  = 8,
    localparam int NL     = clamp_lines(N_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NL-1:0]     pin_in,
    output logic [NL-1:0]     pin_out,
    output logic [NL-1:0]     pin_oe,
    output logic [N_IRQ-1:0]  irq_out
);

    logic [NL-1:0]               pin_sync, line_irq, irq_en_vec;
    line_cfg_t [NL-1:0]          cfg;
    logic [NL-1:0][MAP_BYTE-1:0] map;

    gpio_regs #(.NL(NL), .ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_sync(pin_sync),
        .out_q(pin_out), .dir_q(pin_oe), .cfg_q(cfg), .map_q(map)
    );

    gpio_line_detect #(.NL(NL)) i_detect (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cfg(cfg),
        .pin_sync(pin_sync), .line_irq(line_irq)
    );

    gpio_irq_route #(.NL(NL), .N_IRQ(N_IRQ)) i_route (
        .line_irq(line_irq), .map(map), .irq_out(irq_out)
    );

    for (genvar g = 0; g < NL; g++) begin : g_en
        assign irq_en_vec[g] = cfg[g].en;
    end

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk #(
    parameter int NL     = 32,
    parameter int N_IRQ  = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic [NL-1:0]     pin_in,
    input logic [NL-1:0]     pin_out,
    input logic [NL-1:0]     pin_oe,
    input logic [N_IRQ-1:0]  irq_out,
    input logic [NL-1:0]     irq_en_vec
);

    localparam int MAP_WORDS = (NL + 3) / 4;

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    int  w;
    logic known_addr, wr_cycle;
    assign w          = int'(paddr >> 2);
    assign known_addr = (paddr[1:0] == 2'b00) &&
                        (w <= 6 || (w >= 8 && w < 8 + MAP_WORDS));
    assign wr_cycle   = psel & penable & pwrite & (paddr[1:0] == 2'b00);

    assert_out_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_cycle && w == 1) |=> pin_out == $past(pwdata[NL-1:0]));

    assert_dir_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_cycle && w == 2) |=> pin_oe == $past(pwdata[NL-1:0]));

    assert_data_sync_R4: assert property (@(posedge clk) disable iff (rst)
        (psel && paddr == '0 && since_rst >= 2'd2) |-> prdata == 32'($past(pin_in, 2)));

    assert_hole_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (psel && !known_addr) |-> prdata == '0);

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_en_vec == '0) |-> irq_out == '0);

endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NL(NL), .N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out), .irq_en_vec(irq_en_vec)
);

// File: tb/test_gpio_irq_router.sv
module test_gpio_irq_router;

    localparam int NL = 6;
    localparam int NI = 3;
    localparam logic [7:0] A_DATA = 8'h00, A_OUT = 8'h04, A_DIR = 8'h08, A_EN = 8'h0C,
                           A_POL = 8'h10, A_EDGE = 8'h14, A_SCR = 8'h18,
                           A_MAP0 = 8'h20, A_MAP1 = 8'h24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata, prdata_w;
    logic [NL-1:0] pins = '0;
    logic [NL-1:0] pin_out, pin_oe;
    logic [NI-1:0] irq;
    logic [31:0] pout_w, poe_w;
    logic [3:0]  irq_w;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpio_irq_router #(.N_LINES(NL), .N_IRQ(NI), .ADDR_W(8)) i_gpio_irq_router (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pins),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq)
    );

    // out-of-range line count: builds 32 lines
    gpio_irq_router #(.N_LINES(0), .N_IRQ(4), .ADDR_W(8)) i_wide (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_w), .pin_in(32'h0),
        .pin_out(pout_w), .pin_oe(poe_w), .irq_out(irq_w)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dw);
        @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk); penable = 1'b1; #1 d = prdata; dw = prdata_w;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    function automatic logic [31:0] mapw(int k, int line, int tgt);
        logic [31:0] r;
        for (int j = 0; j < 4; j++)
            r[31-8*j -: 8] = (4*k + j == line) ? 8'(tgt) : 8'hFF;
        return r;
    endfunction

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] d, dw;
        cyc(3); rst = 1'b0; cyc(1);

        // R2 reset state
        chk(32'(pin_oe), 0, "R2 pin_oe");
        chk(32'(irq), 0, "R2 irq_out");
        rd(A_DIR, d, dw);  chk(d, 0, "R2 dir");
        rd(A_EN, d, dw);   chk(d, 0, "R2 enable");
        rd(A_MAP0, d, dw); chk(d, 32'hFFFFFFFF, "R2 map word0");
        rd(A_MAP1, d, dw); chk(d, 32'hFFFF0000, "R2/R5 map word1 upper lines only");

        // R1 line count clamp
        wr(A_DIR, 32'hFFFFFFFF);
        rd(A_DIR, d, dw);
        chk(d, 32'h3F, "R1/R5 six lines, upper bits zero");
        chk(dw, 32'hFFFFFFFF, "R1 invalid count builds 32 lines");
        chk(poe_w, 32'hFFFFFFFF, "R1 wide pin_oe");

        // R3 outputs
        wr(A_OUT, 32'h2A); wr(A_DIR, 32'h0F);
        chk(32'(pin_out), 32'h2A, "R3 pin_out");
        chk(32'(pin_oe), 32'h0F, "R3 pin_oe");

        // R4 synchronized read, write ignored
        pins = 6'h15; cyc(3);
        rd(A_DATA, d, dw); chk(d, 32'h15, "R4 data read");
        wr(A_DATA, 32'hFF);
        rd(A_DATA, d, dw); chk(d, 32'h15, "R4 data write ignored");

        // R5 holes
        rd(8'h1C, d, dw); chk(d, 0, "R5 offset 0x1C");
        rd(8'h28, d, dw); chk(d, 0, "R5 map beyond lines");
        rd(8'h06, d, dw); chk(d, 0, "R5 misaligned");
        wr(8'h1C, 32'hFFFF); wr(8'h05, 32'h11); wr(8'h28, 32'h0);
        rd(A_OUT, d, dw);  chk(d, 32'h2A, "R5 hole writes ignored out");
        rd(A_MAP1, d, dw); chk(d, 32'hFFFF0000, "R5 hole write ignored map");

        // R11 scratch
        wr(A_SCR, 32'hFFFFFFFF); rd(A_SCR, d, dw); chk(d, 32'h3F, "R11 scratch all");
        wr(A_SCR, 32'h12);       rd(A_SCR, d, dw); chk(d, 32'h12, "R11 scratch value");

        // R6 / R7 / R9 sweep: every line, every trigger mode
        for (int l = 0; l < NL; l++) begin
            for (int m = 0; m < 4; m++) begin
                int o = (l + m) % NI;
                logic pol = m[0];
                logic edg = m[1];
                logic idle = ~pol;
                string tg = edg ? "R7/R9" : "R6/R9";
                wr(A_EN, 0);
                pins = idle ? 6'h3F : 6'h00;
                cyc(3);
                wr(A_POL, 32'(pol) << l);
                wr(A_EDGE, 32'(edg) << l);
                wr(A_MAP0, mapw(0, l, o));
                wr(A_MAP1, mapw(1, l, o));
                wr(A_EN, 32'd1 << l);
                chk(32'(irq), 0, {tg, " idle"});
                pins[l] = ~idle;
                cyc(2);
                chk(32'(irq), 32'd1 << o, {tg, " active"});
                cyc(1);
                chk(32'(irq), edg ? 0 : (32'd1 << o), {tg, " one cycle later"});
                pins[l] = idle;
                cyc(2);
                chk(32'(irq), 0, {tg, " return to idle"});
                cyc(1);
                chk(32'(irq), 0, {tg, " stays idle"});
            end
        end

        // R9 unrouted values
        wr(A_EN, 0); pins = 6'h00; cyc(3);
        wr(A_POL, 32'h1); wr(A_EDGE, 0);
        wr(A_MAP0, 32'h03FFFFFF); wr(A_EN, 32'h1);
        pins = 6'h01; cyc(3);
        chk(32'(irq), 0, "R9 target equal to N_IRQ unrouted");
        wr(A_MAP0, 32'h80FFFFFF);
        chk(32'(irq), 0, "R9 negative unrouted");
        wr(A_MAP0, 32'h02FFFFFF);
        chk(32'(irq), 32'h4, "R9 target 2");

        // R8 enable gating keeps settings
        wr(A_EN, 0);
        chk(32'(irq), 0, "R8 disabled");
        rd(A_POL, d, dw);  chk(d, 32'h1, "R8 polarity kept");
        rd(A_MAP0, d, dw); chk(d, 32'h02FFFFFF, "R8 map kept");
        wr(A_EN, 32'h1);
        chk(32'(irq), 32'h4, "R8 re-enabled");

        // R10 shared wire: lines 2 and 4 on wire 1, line 3 on wire 2
        wr(A_EN, 0); pins = 6'h00; cyc(3);
        wr(A_POL, 32'h3F); wr(A_EDGE, 0);
        wr(A_MAP0, 32'hFFFF0102); wr(A_MAP1, 32'h01FF0000);
        wr(A_EN, 32'h1C);
        chk(32'(irq), 0, "R10 none");
        pins = 6'h04; cyc(3); chk(32'(irq), 32'h2, "R10 line2 only");
        pins = 6'h10; cyc(3); chk(32'(irq), 32'h2, "R10 line4 only");
        pins = 6'h14; cyc(3); chk(32'(irq), 32'h2, "R10 both");
        pins = 6'h0C; cyc(3); chk(32'(irq), 32'h6, "R10 independent wires");
        pins = 6'h00; cyc(3); chk(32'(irq), 0, "R10 released");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule